// File: doc/BRIEF.md
# Halt-State Selection and Wake Controller

This block sits beside a small processor core and chooses the low-power state the core drops into when it issues a halt request. A timer-interrupt-enable input makes the choice. With the bit set, the core enters a timer-alive halt. In that state only the main oscillator domain and its periodic timer keep a clock. With the bit clear, the core enters a full halt, where every clock enable is removed. The block also controls the exit path. A periodic timer interrupt brings the core straight back out of the timer-alive halt. An external interrupt ends a full halt, but only after an oscillator stabilisation count. The count length is 256 or 4096 cycles, chosen by a select input.

On each accepted halt request, the block writes the value binary 10 to the core's two-bit interrupt mask so that interrupts are enabled. If an interrupt is already pending at that moment, the core wakes in the same step. After a timer wake, the stabilisation window still runs in the background. If software clears the timer-interrupt-enable bit before that window has ended, the block gates every clock off for the rest of the window.

Top module: `halt_lpm_ctrl`

## Requirements
- R1: While `rst` is sampled high, the block is forced to the run state. After that edge `core_clk_en`, `periph_clk_en` and `tmr_clk_en` are 1, and `stab_busy`, `wake`, `irq_mask_wr`, `wdg_rst_req` are 0 with `irq_mask` = 2'b00.
- R2: A halt request accepted with `tmr_irq_en`=1 and no pending interrupt enters the timer-alive halt. From the next cycle `core_clk_en`=0, `periph_clk_en`=0 and `tmr_clk_en`=1.
- R3: A halt request accepted with `tmr_irq_en`=0 and no pending interrupt enters full halt. From the next cycle all three clock enables are 0.
- R4: Each halt request sampled in the run state makes `irq_mask_wr` high for exactly the next cycle with `irq_mask` = 2'b10 (bit 1 set, bit 0 clear). At all other times `irq_mask` is 2'b00.
- R5: A halt request sampled while `tmr_irq` or any `ext_irq` bit is high leaves all clocks enabled and gives a `wake` pulse in the next cycle.
- R6: The timer-alive halt is left only by `tmr_irq` or by reset. `ext_irq` activity there changes no output.
- R7: `tmr_irq` in the timer-alive halt restores all clock enables in the next cycle with no wait. It pulses `wake` and starts a background window: `stab_busy` stays high for the selected delay length.
- R8: In full halt, any `ext_irq` bit starts the stabilisation count and `tmr_irq` is ignored. All clocks stay off with `stab_busy`=1 for the selected delay length D cycles, then the run state resumes with a `wake` pulse.
- R9: The delay length is `SHORT_DLY` when `dly_sel`=0 and `LONG_DLY` when `dly_sel`=1 (defaults 256 and 4096). The value is sampled in the cycle the count starts.
- R10: If `tmr_irq_en` is sampled 0 while a post-timer-wake window has more than one cycle left, all clocks go off until the window ends. Run then resumes at the same cycle it would otherwise have ended, with a `wake` pulse.
- R11: `wdg_rst_req` pulses for one cycle when a full halt is entered while `wdg_active`=1. It never pulses on entry to the timer-alive halt.
- R12: `wake` is a one-cycle pulse on every return from a halt state to run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | One-cycle halt strobe from the core |
| tmr_irq_en | input | 1 | Timer interrupt enable; picks the halt state |
| tmr_irq | input | 1 | Periodic timer interrupt |
| ext_irq | input | N_EXT | External interrupt requests |
| wdg_active | input | 1 | Watchdog is running |
| dly_sel | input | 1 | 0: short stabilisation delay, 1: long |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | Periodic timer clock enable |
| irq_mask | output | 2 | Forced interrupt-mask value |
| irq_mask_wr | output | 1 | Mask write strobe |
| stab_busy | output | 1 | Stabilisation delay counting |
| wake | output | 1 | One-cycle return-to-run pulse |
| wdg_rst_req | output | 1 | Watchdog reset request on full-halt entry |

## Verification
The bench builds the block with `SHORT_DLY`=8 and `LONG_DLY`=20 and keeps the default four external interrupt lines. These short lengths let every window end within a few dozen cycles. That puts both delay selections, the early-clear cut-over into full halt and the cycle a delay ends within reach of a short run. It also makes it easy to tell an off-by-one in the window length from a correct count.

// File: rtl/halt_lpm_pkg.sv
package halt_lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_TALIVE = 2'd1,
    ST_FULL   = 2'd2,
    ST_STAB   = 2'd3
  } lpm_state_e;

  localparam logic [1:0] MASK_ENABLE_IRQ = 2'b10;
endpackage

// File: rtl/halt_lpm_dly.sv
module halt_lpm_dly #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic sel_long,
  output logic busy,
  output logic last
);
  localparam int CW = (LONG_DLY > SHORT_DLY) ? $clog2(LONG_DLY) : $clog2(SHORT_DLY);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  assign last = busy && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      lim_q <= sel_long ? LONG_M1 : SHORT_M1;
    end else if (abort || last) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= lim_q));
endmodule

// File: rtl/halt_lpm_seq.sv
module halt_lpm_seq
  import halt_lpm_pkg::*;
#(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             tmr_irq_en,
  input  logic             tmr_irq,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             wdg_active,
  input  logic             dly_busy,
  input  logic             dly_last,
  output lpm_state_e       st_q,
  output lpm_state_e       st_d,
  output logic             dly_start,
  output logic             dly_abort,
  output logic             wake_q,
  output logic             mask_wr_q,
  output logic             wdg_rst_q
);
  logic pend;
  logic ext_any;
  logic wake_d;
  logic mask_wr_d;
  logic wdg_rst_d;

  assign ext_any = |ext_irq;
  assign pend    = tmr_irq | ext_any;

  always_comb begin
    st_d      = st_q;
    dly_start = 1'b0;
    dly_abort = 1'b0;
    wake_d    = 1'b0;
    mask_wr_d = 1'b0;
    wdg_rst_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (dly_busy && !dly_last && !tmr_irq_en) begin
          st_d = ST_STAB;
        end else if (halt_req) begin
          mask_wr_d = 1'b1;
          dly_abort = dly_busy;
          if (pend) begin
            wake_d = 1'b1;
          end else if (tmr_irq_en) begin
            st_d = ST_TALIVE;
          end else begin
            st_d      = ST_FULL;
            wdg_rst_d = wdg_active;
          end
        end
      end
      ST_TALIVE: begin
        if (tmr_irq) begin
          st_d      = ST_RUN;
          wake_d    = 1'b1;
          dly_start = 1'b1;
        end
      end
      ST_FULL: begin
        if (ext_any) begin
          st_d      = ST_STAB;
          dly_start = 1'b1;
        end
      end
      ST_STAB: begin
        if (dly_last) begin
          st_d   = ST_RUN;
          wake_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_RUN;
      wake_q    <= 1'b0;
      mask_wr_q <= 1'b0;
      wdg_rst_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      wake_q    <= wake_d;
      mask_wr_q <= mask_wr_d;
      wdg_rst_q <= wdg_rst_d;
    end
  end

  // R6
  talive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TALIVE && !tmr_irq) |=> (st_q == ST_TALIVE));
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FULL && !ext_any) |=> (st_q == ST_FULL));
  // R7
  tmr_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TALIVE && tmr_irq) |=> (st_q == ST_RUN && wake_q && dly_busy));
  // R11
  wdg_full_chk: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_q |-> (st_q == ST_FULL));
  // R4
  mask_src_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr_q |-> $past(halt_req));
endmodule

// File: rtl/halt_lpm_ctrl.sv
module halt_lpm_ctrl
  import halt_lpm_pkg::*;
#(
  parameter int N_EXT     = 4,
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic             tmr_irq_en,
  input  logic             tmr_irq,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             wdg_active,
  input  logic             dly_sel,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             tmr_clk_en,
  output logic [1:0]       irq_mask,
  output logic             irq_mask_wr,
  output logic             stab_busy,
  output logic             wake,
  output logic             wdg_rst_req
);
  lpm_state_e st_q;
  lpm_state_e st_d;
  logic       dly_start;
  logic       dly_abort;
  logic       dly_last;

  halt_lpm_dly #(
    .SHORT_DLY (SHORT_DLY),
    .LONG_DLY  (LONG_DLY)
  ) u_dly (
    .clk      (clk),
    .rst      (rst),
    .start    (dly_start),
    .abort    (dly_abort),
    .sel_long (dly_sel),
    .busy     (stab_busy),
    .last     (dly_last)
  );

  halt_lpm_seq #(
    .N_EXT (N_EXT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .tmr_irq_en (tmr_irq_en),
    .tmr_irq    (tmr_irq),
    .ext_irq    (ext_irq),
    .wdg_active (wdg_active),
    .dly_busy   (stab_busy),
    .dly_last   (dly_last),
    .st_q       (st_q),
    .st_d       (st_d),
    .dly_start  (dly_start),
    .dly_abort  (dly_abort),
    .wake_q     (wake),
    .mask_wr_q  (irq_mask_wr),
    .wdg_rst_q  (wdg_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_clk_en   <= 1'b1;
      periph_clk_en <= 1'b1;
      tmr_clk_en    <= 1'b1;
    end else begin
      core_clk_en   <= (st_d == ST_RUN);
      periph_clk_en <= (st_d == ST_RUN);
      tmr_clk_en    <= (st_d == ST_RUN) || (st_d == ST_TALIVE);
    end
  end

  assign irq_mask = irq_mask_wr ? MASK_ENABLE_IRQ : 2'b00;

  // R10
  early_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && stab_busy && !dly_last && !tmr_irq_en)
      |=> (!core_clk_en && !tmr_clk_en && stab_busy));
  // R2
  talive_clk_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TALIVE) |-> (tmr_clk_en && !periph_clk_en));
endmodule

// File: tb/halt_lpm_ctrl_tb.sv
`timescale 1ns/1ps
module halt_lpm_ctrl_tb;
  localparam int N_EXT = 4;
  localparam int SHORT = 8;
  localparam int LONG  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 1'b0;
  logic tmr_irq_en = 1'b0;
  logic tmr_irq = 1'b0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic wdg_active = 1'b0;
  logic dly_sel = 1'b0;
  logic core_clk_en, periph_clk_en, tmr_clk_en;
  logic [1:0] irq_mask;
  logic irq_mask_wr, stab_busy, wake, wdg_rst_req;

  always #2.5 clk = ~clk;

  halt_lpm_ctrl #(.N_EXT(N_EXT), .SHORT_DLY(SHORT), .LONG_DLY(LONG)) u_dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .tmr_irq_en(tmr_irq_en),
    .tmr_irq(tmr_irq), .ext_irq(ext_irq), .wdg_active(wdg_active),
    .dly_sel(dly_sel), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .tmr_clk_en(tmr_clk_en), .irq_mask(irq_mask), .irq_mask_wr(irq_mask_wr),
    .stab_busy(stab_busy), .wake(wake), .wdg_rst_req(wdg_rst_req));

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  // Behavioural reference: m_st 0 run, 1 timer-alive, 2 full halt, 3 delayed restart
  int m_st = 0;
  int m_left = 0;
  bit m_wake = 0, m_mw = 0, m_wdr = 0;

  always @(posedge clk) begin
    int d;
    d = dly_sel ? LONG : SHORT;
    m_wake = 0; m_mw = 0; m_wdr = 0;
    if (rst) begin
      m_st = 0; m_left = 0;
    end else begin
      case (m_st)
        0: begin
          if (m_left > 1 && !tmr_irq_en) begin
            m_st = 3; m_left = m_left - 1;
          end else if (halt_req) begin
            m_mw = 1; m_left = 0;
            if (tmr_irq || ext_irq != 0) m_wake = 1;
            else if (tmr_irq_en) m_st = 1;
            else begin m_st = 2; m_wdr = wdg_active; end
          end else if (m_left > 0) m_left = m_left - 1;
        end
        1: if (tmr_irq) begin m_st = 0; m_wake = 1; m_left = d; end
        2: if (ext_irq != 0) begin m_st = 3; m_left = d; end
        default: begin
          if (m_left == 1) begin m_st = 0; m_wake = 1; end
          m_left = m_left - 1;
        end
      endcase
    end
  end

  task automatic chk(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk("core_clk_en", core_clk_en, m_st == 0);
      chk("periph_clk_en", periph_clk_en, m_st == 0);
      chk("tmr_clk_en", tmr_clk_en, m_st <= 1);
      chk("stab_busy", stab_busy, m_left > 0);
      chk("wake", wake, m_wake);
      chk("irq_mask_wr", irq_mask_wr, m_mw);
      chk("irq_mask", irq_mask, m_mw ? 2 : 0);
      chk("wdg_rst_req", wdg_rst_req, m_wdr);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic halt_pulse();
    halt_req = 1'b1; cyc(1); halt_req = 1'b0;
  endtask

  int wake_cnt;
  always @(negedge clk) if (model_on && wake) wake_cnt++;

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wake_cnt = 0;
    cyc(3);
    // R1 reset values, checked directly
    cur_req = "R1";
    chk("core_clk_en", core_clk_en, 1); chk("tmr_clk_en", tmr_clk_en, 1);
    chk("stab_busy", stab_busy, 0); chk("irq_mask", irq_mask, 0);
    rst = 1'b0; model_on = 1'b1;
    cyc(2);

    // R2 R4 timer-alive entry, R6 ext ignored, R7 immediate timer wake
    cur_req = "R2"; tmr_irq_en = 1'b1; halt_pulse(); cyc(3);
    cur_req = "R6"; ext_irq = 4'b0100; cyc(4); ext_irq = '0; cyc(2);
    cur_req = "R7"; tmr_irq = 1'b1; cyc(1); tmr_irq = 1'b0; cyc(SHORT + 3);

    // R10 early clear of the enable during the post-wake window
    cur_req = "R10"; halt_pulse(); cyc(2);
    tmr_irq = 1'b1; cyc(1); tmr_irq = 1'b0; cyc(3);
    tmr_irq_en = 1'b0; cyc(SHORT + 2); tmr_irq_en = 1'b1; cyc(2);

    // R3 R11 full halt with watchdog, R8 tmr ignored, short delay R9
    cur_req = "R3"; tmr_irq_en = 1'b0; wdg_active = 1'b1; halt_pulse(); cyc(3);
    cur_req = "R8"; tmr_irq = 1'b1; cyc(2); tmr_irq = 1'b0; cyc(2);
    ext_irq = 4'b0001; cyc(1); ext_irq = '0; cyc(SHORT + 3);

    // R9 long delay after full halt
    cur_req = "R9"; dly_sel = 1'b1; wdg_active = 1'b0; halt_pulse(); cyc(2);
    ext_irq = 4'b1000; cyc(1); ext_irq = '0; cyc(LONG + 3);

    // R9 long window after timer wake
    tmr_irq_en = 1'b1; halt_pulse(); cyc(2);
    tmr_irq = 1'b1; cyc(1); tmr_irq = 1'b0; cyc(LONG + 3);
    dly_sel = 1'b0;

    // R5 pending interrupt at halt request
    cur_req = "R5"; tmr_irq_en = 1'b0; ext_irq = 4'b0010; halt_pulse(); ext_irq = '0; cyc(3);
    tmr_irq_en = 1'b1; tmr_irq = 1'b1; halt_pulse(); tmr_irq = 1'b0; cyc(3);

    // R11 no watchdog request on timer-alive entry
    cur_req = "R11"; wdg_active = 1'b1; halt_pulse(); cyc(3);
    tmr_irq = 1'b1; cyc(1); tmr_irq = 1'b0; cyc(SHORT + 2);

    // R6 reset leaves timer-alive halt
    cur_req = "R6"; halt_pulse(); cyc(3);
    rst = 1'b1; cyc(1); rst = 1'b0; cyc(3);

    // R12 wake pulse count: timer wakes 4, full-halt exits 2, immediate 2, R10 1
    cur_req = "R12";
    chk("wake_count", wake_cnt, 9);

    model_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule